// File: doc/BRIEF.md
# Floating-Point Status Word Controller

This block owns the status word of a scalar floating-point unit. Each finished arithmetic or conversion operation hands it a five-bit vector of IEEE exception flags over a valid/ready stream. The block translates that vector into its current-exception bits and tests the result against the trap-enable bits. If any raised exception is enabled, it asks for a trap and stamps the trap-type field. Otherwise it adds the current exceptions into the accrued field. Software can also overwrite the register. A narrow load and a wide load each have their own mask of writable bits. The two-bit rounding field is decoded into a one-hot rounding-mode output for the datapath.

The flag stream uses one back-pressure rule. `flag_ready` drops in any cycle where a software load is requested. A producer that sees this must hold `flag_valid` and `flag_bits` steady until a cycle with `flag_ready` high. A beat transfers when `flag_valid` and `flag_ready` are both high at a rising clock edge. The transfer consumes the vector, so the next operation starts from zero. The control pins (`ld_*`, `trap_*`, `rnd_mode`) have no handshake.

Register layout, least significant bit first:
- Current exceptions at 4:0, in the order inexact, divide-by-zero, underflow, overflow, invalid.
- Accrued exceptions at 9:5, in the same order.
- Trap-type field at 16:14.
- Trap enables at 27:23, in the same order as the current exceptions.
- Rounding field at 31:30.

All other bits stay zero.

Top module: `fpsr_ctrl`

## Requirements
- R1: After reset the status word is 0, `rnd_mode` is 4'b0001, `trap_req` is 0, `trap_num` is 0, and `flag_ready` is 1.
- R2: On an accepted non-zero beat, the incoming `flag_bits` map into the current-exception bits of `fsr` in the next cycle as follows. Bit 0 (invalid) goes to fsr[4], bit 1 (divide-by-zero) to fsr[1], bit 2 (overflow) to fsr[3], bit 3 (underflow) to fsr[2], and bit 4 (inexact) to fsr[0]. Each mapped bit is ORed into bits that are already set, so no current-exception bit is ever cleared by a beat.
- R3: When the updated current exceptions AND the enables fsr[27:23] give zero, the full updated current-exception vector is ORed into fsr[9:5], and `trap_req` stays 0.
- R4: When the updated current exceptions AND the enables are non-zero, several things happen in the cycle after the beat. fsr[16:14] becomes 3'b001 and fsr[9:5] is unchanged. `trap_req` is 1 for that cycle, and `trap_num` shows the parameter TRAP_NUM (default 8'h08). In any cycle without a trap, `trap_num` is 0.
- R5: An accepted beat whose `flag_bits` are all zero leaves `fsr` unchanged and raises no trap.
- R6: `rnd_mode` is a one-hot decode of fsr[31:30]: 00 gives bit 0 (nearest-even), 01 gives bit 1 (toward zero), 10 gives bit 2 (toward plus infinity), and 11 gives bit 3 (toward minus infinity). Any other code falls back to bit 1.
- R7: A narrow load (`ld_en`=1, `ld_wide`=0) writes `ld_data` into the bits of mask 32'hCF8003FF and keeps every other bit of `fsr`. In particular, the trap-type field is kept.
- R8: A wide load (`ld_en`=1, `ld_wide`=1) writes `ld_data` into the bits of mask 32'hCF81C3FF and keeps every other bit.
- R9: While `ld_en` is 1, `flag_ready` is 0, and only the load affects `fsr`. A beat held across that cycle is applied in the first following cycle with `ld_en` low.
- R10: With `ld_en` low, `flag_ready` is 1, and an idle cycle (`flag_valid`=0) leaves `fsr` unchanged with `trap_req` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_valid | input | 1 | Exception-flag beat present |
| flag_ready | output | 1 | Block can take a flag beat this cycle |
| flag_bits | input | 5 | Flags: 0 invalid, 1 div-by-zero, 2 overflow, 3 underflow, 4 inexact |
| ld_en | input | 1 | Software load of the status word |
| ld_wide | input | 1 | Selects the wide writable mask for the load |
| ld_data | input | 32 | Value offered by the software load |
| fsr | output | 32 | Current status word |
| rnd_mode | output | 4 | One-hot rounding mode |
| trap_req | output | 1 | One-cycle floating-point trap request |
| trap_num | output | 8 | Trap number while `trap_req` is high, else 0 |

## Verification
A software load and a flag beat can meet in the same cycle. The bench provokes this by holding a non-zero flag beat valid while it pulses a narrow load. It checks three things: `flag_ready` is low in that cycle, the word afterwards equals the masked load alone, and the held beat lands exactly one cycle later on top of the loaded value. The other pairing is a flag beat whose mapped flags hit an enabled exception while earlier accrued bits are set. That case is judged by confirming that the accrued field stays frozen while the trap type is written.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int NFLAG    = 5;
  localparam int CEXC_LSB = 0;
  localparam int AEXC_LSB = 5;
  localparam int FTT_LSB  = 14;
  localparam int FTT_W    = 3;
  localparam int TEM_LSB  = 23;
  localparam int RND_LSB  = 30;
  localparam int RND_W    = 2;
  localparam int NMODE    = 1 << RND_W;

  typedef enum logic [RND_W-1:0] {
    RC_NEAREST = 2'b00,
    RC_ZERO    = 2'b01,
    RC_PLUS    = 2'b10,
    RC_MINUS   = 2'b11
  } rnd_code_t;

  // Incoming order: 0 nv, 1 dz, 2 of, 3 uf, 4 nx.
  // Register order: 0 nx, 1 dz, 2 uf, 3 of, 4 nv.
  function automatic logic [NFLAG-1:0] remap_flags(input logic [NFLAG-1:0] raw);
    logic [NFLAG-1:0] m;
    m[0] = raw[4];
    m[1] = raw[1];
    m[2] = raw[3];
    m[3] = raw[2];
    m[4] = raw[0];
    return m;
  endfunction
endpackage

// File: rtl/fpsr_flag_merge.sv
module fpsr_flag_merge
  import fpsr_pkg::*;
#(
  parameter int W = 32,
  parameter logic [FTT_W-1:0] FTT_IEEE = 3'b001
) (
  input  logic [W-1:0]     cur,
  input  logic [NFLAG-1:0] raw_flags,
  output logic [W-1:0]     nxt,
  output logic             trap_due
);
  logic [NFLAG-1:0] cexc_upd;
  logic [NFLAG-1:0] enables;

  always_comb begin
    cexc_upd = cur[CEXC_LSB +: NFLAG] | remap_flags(raw_flags);
    enables  = cur[TEM_LSB +: NFLAG];
    trap_due = |(cexc_upd & enables);
    nxt      = cur;
    nxt[CEXC_LSB +: NFLAG] = cexc_upd;
    if (trap_due) begin
      nxt[FTT_LSB +: FTT_W] = FTT_IEEE;
    end else begin
      nxt[AEXC_LSB +: NFLAG] = cur[AEXC_LSB +: NFLAG] | cexc_upd;
    end
  end
endmodule

// File: rtl/fpsr_load_merge.sv
module fpsr_load_merge #(
  parameter int W = 32,
  parameter logic [W-1:0] NARROW_MASK = 32'hCF8003FF,
  parameter logic [W-1:0] WIDE_MASK   = 32'hCF81C3FF
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] data,
  input  logic         wide,
  output logic [W-1:0] loaded
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic wr_ok;
    assign wr_ok     = wide ? WIDE_MASK[b] : NARROW_MASK[b];
    assign loaded[b] = wr_ok ? data[b] : cur[b];
  end
endmodule

// File: rtl/fpsr_rnd_decode.sv
module fpsr_rnd_decode
  import fpsr_pkg::*;
(
  input  logic [RND_W-1:0] code,
  output logic [NMODE-1:0] mode_oh
);
  always_comb begin
    unique case (rnd_code_t'(code))
      RC_NEAREST: mode_oh = 4'b0001;
      RC_ZERO:    mode_oh = 4'b0010;
      RC_PLUS:    mode_oh = 4'b0100;
      RC_MINUS:   mode_oh = 4'b1000;
      default:    mode_oh = 4'b0010;
    endcase
  end
endmodule

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
  import fpsr_pkg::*;
#(
  parameter int W = 32,
  parameter int TN_W = 8,
  parameter logic [TN_W-1:0] TRAP_NUM = 8'h08,
  parameter logic [W-1:0] NARROW_MASK = 32'hCF8003FF,
  parameter logic [W-1:0] WIDE_MASK   = 32'hCF81C3FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag_valid,
  output logic             flag_ready,
  input  logic [NFLAG-1:0] flag_bits,
  input  logic             ld_en,
  input  logic             ld_wide,
  input  logic [W-1:0]     ld_data,
  output logic [W-1:0]     fsr,
  output logic [NMODE-1:0] rnd_mode,
  output logic             trap_req,
  output logic [TN_W-1:0]  trap_num
);
  logic [W-1:0] fsr_q;
  logic [W-1:0] merged;
  logic [W-1:0] loaded;
  logic         due;
  logic         trap_q;
  logic         take;

  assign flag_ready = !ld_en;
  assign take       = flag_valid && flag_ready && (|flag_bits);

  fpsr_flag_merge #(.W(W)) u_merge (
    .cur(fsr_q), .raw_flags(flag_bits), .nxt(merged), .trap_due(due)
  );

  fpsr_load_merge #(.W(W), .NARROW_MASK(NARROW_MASK), .WIDE_MASK(WIDE_MASK)) u_load (
    .cur(fsr_q), .data(ld_data), .wide(ld_wide), .loaded(loaded)
  );

  fpsr_rnd_decode u_rnd (
    .code(fsr_q[RND_LSB +: RND_W]), .mode_oh(rnd_mode)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_q  <= '0;
      trap_q <= 1'b0;
    end else begin
      trap_q <= 1'b0;
      if (ld_en) begin
        fsr_q <= loaded;
      end else if (take) begin
        fsr_q  <= merged;
        trap_q <= due;
      end
    end
  end

  assign fsr      = fsr_q;
  assign trap_req = trap_q;
  assign trap_num = trap_q ? TRAP_NUM : '0;

  // R4: accrued field frozen across a trap, trap type stamped
  a_r4_accrued_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> fsr[AEXC_LSB +: NFLAG] == $past(fsr[AEXC_LSB +: NFLAG]));
  a_r4_ftt_stamped: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> fsr[FTT_LSB +: FTT_W] == 3'b001);
  // R2: a beat never clears a current-exception bit
  a_r2_cexc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_valid && flag_ready) |=>
      (fsr[CEXC_LSB +: NFLAG] & $past(fsr[CEXC_LSB +: NFLAG])) == $past(fsr[CEXC_LSB +: NFLAG]));
  // R5: empty flag vector holds the word
  a_r5_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_valid && flag_ready && flag_bits == '0) |=> ($stable(fsr) && !trap_req));
  // R9: a load cycle never produces a trap
  a_r9_load_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> !trap_req);
  // R6: exactly one rounding mode
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rnd_mode) == 1);
endmodule

// File: tb/fpsr_ctrl_test.sv
module fpsr_ctrl_test;
  localparam logic [31:0] NM = 32'hCF8003FF;
  localparam logic [31:0] WM = 32'hCF81C3FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flag_valid = 1'b0;
  logic        flag_ready;
  logic [4:0]  flag_bits = '0;
  logic        ld_en = 1'b0;
  logic        ld_wide = 1'b0;
  logic [31:0] ld_data = '0;
  logic [31:0] fsr;
  logic [3:0]  rnd_mode;
  logic        trap_req;
  logic [7:0]  trap_num;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [31:0] f;
    logic        t;
    string       tag;
  } exp_t;
  exp_t sb[$];
  logic [31:0] model_fsr = '0;

  always #5 clk = ~clk;

  fpsr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .flag_valid(flag_valid), .flag_ready(flag_ready),
    .flag_bits(flag_bits), .ld_en(ld_en), .ld_wide(ld_wide), .ld_data(ld_data),
    .fsr(fsr), .rnd_mode(rnd_mode), .trap_req(trap_req), .trap_num(trap_num)
  );

  function automatic logic [3:0] exp_rnd(input logic [31:0] f);
    case (f[31:30])
      2'b00:   return 4'b0001;
      2'b01:   return 4'b0010;
      2'b10:   return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected result pushed to scoreboard
  task automatic step(input string tag, input logic v, input logic [4:0] fl,
                      input logic ld, input logic wd, input logic [31:0] d);
    exp_t e;
    logic [4:0] c;
    logic [31:0] m;
    @(negedge clk);
    flag_valid = v; flag_bits = fl; ld_en = ld; ld_wide = wd; ld_data = d;
    #1;
    check({tag, " R9/R10 ready"}, 64'(flag_ready), 64'(!ld));
    e.t = 1'b0;
    e.tag = tag;
    if (ld) begin
      m = wd ? WM : NM;
      model_fsr = (d & m) | (model_fsr & ~m);
    end else if (v && fl != 5'b0) begin
      c = {fl[0], fl[2], fl[3], fl[1], fl[4]} | model_fsr[4:0];
      model_fsr[4:0] = c;
      if ((c & model_fsr[27:23]) != 5'b0) begin
        model_fsr[16:14] = 3'b001;
        e.t = 1'b1;
      end else begin
        model_fsr[9:5] = model_fsr[9:5] | c;
      end
    end
    e.f = model_fsr;
    sb.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " fsr"}, 64'(fsr), 64'(e.f));
      check({e.tag, " trap_req"}, 64'(trap_req), 64'(e.t));
      check({e.tag, " R4 trap_num"}, 64'(trap_num), e.t ? 64'h08 : 64'h0);
      check({e.tag, " R6 rnd_mode"}, 64'(rnd_mode), 64'(exp_rnd(e.f)));
    end
  end

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 fsr", 64'(fsr), 64'h0);
    check("R1 rnd", 64'(rnd_mode), 64'h1);
    check("R1 trap", 64'({trap_req, trap_num}), 64'h0);
    check("R1 ready", 64'(flag_ready), 64'h1);

    step("R2 R3 invalid",        1, 5'b00001, 0, 0, 32'h0);
    step("R2 R3 inexact+dz",     1, 5'b10010, 0, 0, 32'h0);
    step("R2 R3 of+uf",          1, 5'b01100, 0, 0, 32'h0);
    step("R5 zero beat",         1, 5'b00000, 0, 0, 32'h0);
    step("R10 idle",             0, 5'b11111, 0, 0, 32'h0);
    step("R7 narrow ones",       0, 5'b0, 1, 0, 32'hFFFFFFFF);
    step("R8 wide zero",         0, 5'b0, 1, 1, 32'h0);
    step("R8 wide ones",         0, 5'b0, 1, 1, 32'hFFFFFFFF);
    step("R7 narrow zero keeps", 0, 5'b0, 1, 0, 32'h0);
    step("R6 R8 clear",          0, 5'b0, 1, 1, 32'h0);
    step("R6 zero",              0, 5'b0, 1, 0, 32'h40000000);
    step("R6 plus",              0, 5'b0, 1, 0, 32'h80000000);
    step("R6 minus",             0, 5'b0, 1, 0, 32'hC0000000);
    step("R6 nearest accrued",   0, 5'b0, 1, 0, 32'h00000260);
    step("R3 prime accrued",     1, 5'b00001, 0, 0, 32'h0);
    step("R4 enable of",         0, 5'b0, 1, 0, 32'h04000270);
    step("R4 overflow trap",     1, 5'b00100, 0, 0, 32'h0);
    step("R4 sticky retrap",     1, 5'b01000, 0, 0, 32'h0);
    step("R10 after trap",       0, 5'b0, 0, 0, 32'h0);
    step("R9 load wins",         1, 5'b00001, 1, 0, 32'h80000000);
    step("R9 held beat lands",   1, 5'b00001, 0, 0, 32'h0);
    step("R5 zero after",        1, 5'b00000, 0, 0, 32'h0);

    @(negedge clk);
    flag_valid = 0; ld_en = 0;
    repeat (3) @(posedge clk);
    #3;
    check("scoreboard drained", 64'(sb.size()), 64'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule